// File: doc/BRIEF.md
# Vehicle Network CRC-8 Frame Engine

This block computes and checks the eight-bit cyclic redundancy code carried by frames on a Class B vehicle network. A frame begins with a clear strobe that presets the running remainder. After that, each accepted byte is folded into the remainder, one whole byte per clock. There are no gaps required between bytes.

On transmit, the host feeds the data bytes in order. It then reads `crc_byte`, which is the one's complement of the current remainder, and appends it as the check byte. On receive, the host feeds every data byte and then the received check byte. It then pulses `frame_end`. The block compares the remainder against the fixed residue of an error-free frame and raises either a pass flag or an error flag. Symbol timing, bus signalling and arbitration are handled elsewhere.

Top module: `vnet_crc8`

## Requirements
- R1: After reset, `crc_byte` reads 0x00 (the remainder is 0xFF) and `crc_ok` and `crc_err` are both low.
- R2: A `sof_clr` pulse presets the remainder to 0xFF, so `crc_byte` reads 0x00 on the cycle after the pulse.
- R3: Each cycle with `byte_vld` high, the byte on `byte_in` is shifted into the remainder most significant bit first, using divisor x^8+x^4+x^3+x^2+1 (0x1D). The new remainder is visible one cycle later, and bytes may arrive on consecutive cycles. For example, the ASCII bytes "123456789" give a check byte of 0x4B.
- R4: `crc_byte` always equals the bitwise complement of the current remainder.
- R5: In a cycle with neither `byte_vld` nor `sof_clr` high, the remainder, and hence `crc_byte`, does not change.
- R6: When `sof_clr` and `byte_vld` are high in the same cycle, the clear wins and the byte is dropped.
- R7: A `frame_end` pulse, while the remainder equals 0xC4 and no error is held, sets `crc_ok` on the next cycle.
- R8: A `frame_end` pulse, while the remainder differs from 0xC4, sets `crc_err` and clears `crc_ok` on the next cycle.
- R9: `crc_err` stays high through later bytes and `frame_end` pulses until `sof_clr`, which clears both flags. The flags are never both high.
- R10: A frame whose data bytes are followed by the `crc_byte` value produced for them always ends at residue 0xC4 and reports `crc_ok`.
- R11: `frame_end` samples the remainder as it stood before any byte accepted in the same cycle. A `sof_clr` in the same cycle overrides `frame_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_clr | input | 1 | Start-of-frame clear strobe |
| byte_vld | input | 1 | Byte on `byte_in` is accepted this cycle |
| byte_in | input | 8 | Frame byte |
| frame_end | input | 1 | End-of-data strobe that samples the residue |
| crc_byte | output | 8 | Complement of the running remainder (check byte to send) |
| crc_ok | output | 1 | Last sampled residue matched 0xC4 |
| crc_err | output | 1 | Residue mismatch seen since the last clear |

## Verification
The bench drives a bit-serial reference remainder alongside the design and compares all outputs on every cycle.

It feeds back-to-back byte streams, which would expose a byte engine that takes more than one cycle or that shifts least significant bit first. It also checks the published "123456789" value, which catches a wrong polynomial or a wrong preset.

It sends good frames made by appending the generated check byte, and frames with one bit flipped. A residue compare against the wrong constant, or against the non-complemented value, would misreport these.

Coincident strobes (clear with a byte, end with a byte, clear with end) and repeated end pulses after an error target priority mistakes, and an error flag that is not sticky.

// File: rtl/vnet_crc_pkg.sv
package vnet_crc_pkg;
   localparam int unsigned CRC_W   = 8;
   localparam int unsigned DATA_W  = 8;
   localparam logic [CRC_W-1:0] POLY    = 8'h1D;
   localparam logic [CRC_W-1:0] PRESET  = 8'hFF;
   localparam logic [CRC_W-1:0] RESIDUE = 8'hC4;
   typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/crc8_byte_step.sv
module crc8_byte_step #(
   parameter int unsigned CRC_W = vnet_crc_pkg::CRC_W,
   parameter int unsigned DATA_W = vnet_crc_pkg::DATA_W,
   parameter logic [CRC_W-1:0] POLY = vnet_crc_pkg::POLY,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic [CRC_W-1:0]  rem_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CRC_W-1:0]  rem_o
);
   localparam int unsigned STAGES = DATA_W;

   generate
      if (CRC_W < 2) begin : g_bad_w
         $error("crc8_byte_step: CRC_W must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_d
         $error("crc8_byte_step: DATA_W must be at least 1");
      end
   endgenerate

   logic [CRC_W-1:0] chain [STAGES+1];
   assign chain[0] = rem_i;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         logic in_bit;
         logic fb;
         if (MSB_FIRST) begin : g_msb
            assign in_bit = data_i[DATA_W-1-g];
         end else begin : g_lsb
            assign in_bit = data_i[g];
         end
         assign fb = chain[g][CRC_W-1] ^ in_bit;
         assign chain[g+1] = {chain[g][CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & POLY);
      end
   endgenerate

   assign rem_o = chain[STAGES];
endmodule

// File: rtl/crc8_rem_reg.sv
module crc8_rem_reg #(
   parameter int unsigned CRC_W = vnet_crc_pkg::CRC_W,
   parameter logic [CRC_W-1:0] PRESET = vnet_crc_pkg::PRESET
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [CRC_W-1:0] next_rem,
   output logic [CRC_W-1:0] rem
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rem <= PRESET;
      else if (clr)  rem <= PRESET;
      else if (load) rem <= next_rem;
   end

   // R2
   preset_after_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> rem == PRESET);
   // R5
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load) |=> $stable(rem));
   // R6
   clr_beats_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && load) |=> rem == PRESET);
endmodule

// File: rtl/crc8_residue_flags.sv
module crc8_residue_flags #(
   parameter int unsigned CRC_W = vnet_crc_pkg::CRC_W,
   parameter logic [CRC_W-1:0] RESIDUE = vnet_crc_pkg::RESIDUE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             sample,
   input  logic [CRC_W-1:0] rem,
   output logic             ok,
   output logic             err
);
   logic miss;
   assign miss = (rem != RESIDUE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ok  <= 1'b0;
         err <= 1'b0;
      end else if (clr) begin
         ok  <= 1'b0;
         err <= 1'b0;
      end else if (sample) begin
         err <= err | miss;
         ok  <= ~miss & ~err;
      end
   end

   // R9
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ok && err));
   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !clr) |=> err);
   // R8
   mismatch_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sample && !clr && miss) |=> (err && !ok));
   // R7
   match_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sample && !clr && !miss && !err) |=> ok);
   // R11
   clr_beats_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!ok && !err));
endmodule

// File: rtl/vnet_crc8.sv
module vnet_crc8 #(
   parameter int unsigned CRC_W = vnet_crc_pkg::CRC_W,
   parameter int unsigned DATA_W = vnet_crc_pkg::DATA_W,
   parameter logic [CRC_W-1:0] POLY = vnet_crc_pkg::POLY,
   parameter logic [CRC_W-1:0] PRESET = vnet_crc_pkg::PRESET,
   parameter logic [CRC_W-1:0] RESIDUE = vnet_crc_pkg::RESIDUE,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof_clr,
   input  logic              byte_vld,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              frame_end,
   output logic [CRC_W-1:0]  crc_byte,
   output logic              crc_ok,
   output logic              crc_err
);
   logic [CRC_W-1:0] rem_q;
   logic [CRC_W-1:0] rem_next;

   crc8_byte_step #(
      .CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY), .MSB_FIRST(MSB_FIRST)
   ) u_step (
      .rem_i(rem_q), .data_i(byte_in), .rem_o(rem_next)
   );

   crc8_rem_reg #(.CRC_W(CRC_W), .PRESET(PRESET)) u_rem (
      .clk(clk), .rst_n(rst_n), .clr(sof_clr), .load(byte_vld),
      .next_rem(rem_next), .rem(rem_q)
   );

   crc8_residue_flags #(.CRC_W(CRC_W), .RESIDUE(RESIDUE)) u_flags (
      .clk(clk), .rst_n(rst_n), .clr(sof_clr), .sample(frame_end),
      .rem(rem_q), .ok(crc_ok), .err(crc_err)
   );

   assign crc_byte = ~rem_q;

   // R3
   byte_folds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !sof_clr) |=> rem_q == $past(rem_next));
   // R4
   complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (crc_byte ^ rem_q) == {CRC_W{1'b1}});
endmodule

// File: tb/vnet_crc8_bench.sv
module vnet_crc8_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sof_clr = 1'b0;
   logic       byte_vld = 1'b0;
   logic [7:0] byte_in = 8'h00;
   logic       frame_end = 1'b0;
   logic [7:0] crc_byte;
   logic       crc_ok;
   logic       crc_err;

   int checks = 0;
   int errors = 0;
   logic [7:0] m_rem = 8'hFF;
   logic       m_ok = 1'b0;
   logic       m_err = 1'b0;

   always #5 clk = ~clk;

   vnet_crc8 u_vnet_crc8 (
      .clk(clk), .rst_n(rst_n), .sof_clr(sof_clr), .byte_vld(byte_vld),
      .byte_in(byte_in), .frame_end(frame_end), .crc_byte(crc_byte),
      .crc_ok(crc_ok), .crc_err(crc_err)
   );

   function automatic logic [7:0] ref_fold(input logic [7:0] r, input logic [7:0] d);
      logic [7:0] x = r;
      for (int i = 7; i >= 0; i--) begin
         logic top = x[7] ^ d[i];
         x = x << 1;
         if (top) x = x ^ 8'h1D;
      end
      return x;
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      check({tag, " crc_byte"}, crc_byte, ~m_rem);
      check({tag, " crc_ok"}, {7'd0, crc_ok}, {7'd0, m_ok});
      check({tag, " crc_err"}, {7'd0, crc_err}, {7'd0, m_err});
   endtask

   // one clock: drive at negedge, model updates with the edge, compare at next negedge
   task automatic cyc(input logic s, input logic v, input logic [7:0] d,
                      input logic e, input string tag);
      logic [7:0] r0;
      sof_clr = s; byte_vld = v; byte_in = d; frame_end = e;
      @(posedge clk);
      r0 = m_rem;
      if (s) begin
         m_rem = 8'hFF; m_ok = 1'b0; m_err = 1'b0;
      end else begin
         if (v) m_rem = ref_fold(r0, d);
         if (e) begin
            m_ok  = (r0 == 8'hC4) && !m_err;
            m_err = m_err || (r0 != 8'hC4);
         end
      end
      @(negedge clk);
      compare_all(tag);
      sof_clr = 1'b0; byte_vld = 1'b0; frame_end = 1'b0;
   endtask

   task automatic frame(input int n, input bit append, input int flip, input string tag);
      logic [7:0] chk;
      cyc(1'b1, 1'b0, 8'h00, 1'b0, "R2 clear");
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 8'($urandom), 1'b0, "R3 byte");
      if (append) begin
         chk = ~m_rem;
         check("R4 check byte", crc_byte, chk);
         if (flip >= 0) chk[flip] = ~chk[flip];
         cyc(1'b0, 1'b1, chk, 1'b0, "R3 check byte in");
         if (flip < 0) check("R10 residue", ~crc_byte, 8'hC4);
      end
      cyc(1'b0, 1'b0, 8'h00, 1'b1, tag);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      static byte msg [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
      repeat (2) @(negedge clk);
      compare_all("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R1 after release");

      // known vector, back to back
      cyc(1'b1, 1'b0, 8'h00, 1'b0, "R2 clear");
      foreach (msg[i]) cyc(1'b0, 1'b1, msg[i], 1'b0, "R3 vector");
      check("R3 known 123456789", crc_byte, 8'h4B);

      // idle cycles keep the remainder
      cyc(1'b0, 1'b0, 8'hA5, 1'b0, "R5 idle");
      cyc(1'b0, 1'b0, 8'h5A, 1'b0, "R5 idle");

      // clear with byte
      cyc(1'b1, 1'b1, 8'h77, 1'b0, "R6 clear wins");
      check("R6 preset", crc_byte, 8'h00);

      // good frames of several lengths
      for (int n = 1; n <= 12; n++) frame(n, 1'b1, -1, "R7 R10 good frame");
      // corrupted check bytes
      for (int b = 0; b < 8; b++) frame(3 + b, 1'b1, b, "R8 corrupt");

      // sticky error: more bytes and end pulses, then a residue pulse
      cyc(1'b0, 1'b1, 8'h12, 1'b0, "R9 byte after err");
      cyc(1'b0, 1'b0, 8'h00, 1'b1, "R9 end again");
      frame(4, 1'b1, -1, "R9 cleared good");
      cyc(1'b0, 1'b0, 8'h00, 1'b1, "R9 end repeated");

      // end with byte in same cycle samples old remainder
      cyc(1'b1, 1'b0, 8'h00, 1'b0, "R2 clear");
      cyc(1'b0, 1'b1, 8'h3C, 1'b0, "R3 byte");
      cyc(1'b0, 1'b1, ~m_rem, 1'b1, "R11 end with byte");
      cyc(1'b0, 1'b0, 8'h00, 1'b1, "R11 end after");
      // clear with end
      cyc(1'b1, 1'b0, 8'h00, 1'b1, "R11 clear beats end");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule